// File: doc/BRIEF.md
# Per-Line Edge/Level Interrupt Request Front End

This block sits at the input of a sixteen-input interrupt controller. Every request line is brought into the clock domain through a two-stage synchronizer. Each line is then handled either as an edge source or as a level source. An edge source latches a pending bit on each low-to-high transition, and the bit stays set until the CPU acknowledges that line. A level source has a pending bit that simply tracks the synchronized line. A line that is still high after its handler has run therefore requests again.

The trigger mode of each line comes from one of two places. Two byte-wide trigger-select registers give one bit per line, where 1 selects level and 0 selects edge. A single global mode bit applies to all lines when the per-line override is switched off. Software reaches the select registers and a small control register through a byte-wide I/O port. The pending bits are read as two bytes on a separate read port. A registered interrupt output goes high when the master enable is set and any pending bit is set.

Top module: `irq_edge_level_fe`

## Requirements
- R1: After synchronous reset both trigger-select registers and the control register read 0x00, every line is in edge mode, all pending bits are 0 and `int_o` is 0.
- R2: In edge mode a pending bit is set by a low-to-high transition of the synchronized line. A line that is already high or stays high sets no new bit after an acknowledge.
- R3: In edge mode an acknowledge (`ack_i`=1 with `ack_irq_i`=n) clears pending bit n only. Bits of other lines are unchanged.
- R4: In edge mode, when an acknowledge for line n and a new rising edge on line n take effect in the same cycle, the bit stays set.
- R5: In level mode the pending bit equals the synchronized line value. An acknowledge has no lasting effect on it, so a line that is still high stays pending.
- R6: A write to address 0x4D0 loads the select bits for lines 0-7, and a write to 0x4D1 loads those for lines 8-15 (bit k of the byte is line 8*byte+k). Both read back at the same addresses. Bit value 1 means level and 0 means edge. All 16 bits are writable, and none is forced.
- R7: The control register is at address 0x4D2. Bit 0 is the master enable, bit 1 is the global level mode and bit 2 is the per-line override enable. With bit 2 at 0, every line takes its mode from bit 1. With bit 2 at 1, each line takes its mode from its select bit.
- R8: `int_o` is a registered output. It is 1 one cycle after the master enable is 1 and at least one pending bit is set, and 0 otherwise.
- R9: `irr_byte_o` returns pending bits 0-7 when `irr_sel_i`=0 and bits 8-15 when `irr_sel_i`=1. It is registered and valid the cycle after the select is applied.
- R10: `io_rdata_o` is registered and is loaded on a read strobe. Reads of unmapped addresses return 0x00, and writes to unmapped addresses change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_line_i | input | 16 | Asynchronous request lines, active high |
| io_addr_i | input | 16 | I/O port address |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | Registered I/O read data |
| irr_sel_i | input | 1 | Pending-byte select (0 = lines 0-7, 1 = lines 8-15) |
| irr_byte_o | output | 8 | Registered pending byte |
| ack_i | input | 1 | Acknowledge pulse |
| ack_irq_i | input | 4 | Line number being acknowledged |
| int_o | output | 1 | Interrupt request to the CPU |

## Verification
Several properties are checked by assertions on every cycle and for every line:
- An edge-mode pending bit holds until its own acknowledge, and cannot appear without a rising edge.
- A rising edge beats a simultaneous acknowledge.
- A level-mode bit tracks the synchronized line.
- The interrupt output stays low while the master enable is off.
- The registers come out of reset cleared.

Other behaviour only the bench scenarios can show. This covers the address decode and readback of every select bit, the choice between the global bit and the per-line bits, and the byte order of the pending read port. It also covers the end-to-end story of a line held high that is acknowledged and then re-requests in level mode but stays quiet in edge mode.

// File: rtl/irq_fe_pkg.sv
package irq_fe_pkg;
  localparam int CTRL_BITS  = 3;
  localparam int CTRL_MEN   = 0;
  localparam int CTRL_GLVL  = 1;
  localparam int CTRL_OVR   = 2;
endpackage

// File: rtl/irq_sync_edge.sv
module irq_sync_edge #(
  parameter int NUM_LINES = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] line_i,
  output logic [NUM_LINES-1:0] sync_o,
  output logic [NUM_LINES-1:0] rise_o
);
  logic [NUM_LINES-1:0] meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta_q <= '0;
      sync_q <= '0;
      prev_q <= '0;
    end else begin
      meta_q <= line_i;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign sync_o = sync_q;
  assign rise_o = sync_q & ~prev_q;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_chk
      // R2: one transition yields a single-cycle rise indication
      p_rise_once_r2: assert property (@(posedge clk) disable iff (rst)
        rise_o[g] |=> !rise_o[g]);
    end
  endgenerate
endmodule

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
  parameter int NUM_LINES = 16,
  localparam int IDW = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] sync_i,
  input  logic [NUM_LINES-1:0] rise_i,
  input  logic [NUM_LINES-1:0] lvl_mode_i,
  input  logic                 ack_i,
  input  logic [IDW-1:0]       ack_id_i,
  output logic [NUM_LINES-1:0] irr_o
);
  logic [NUM_LINES-1:0] clr, irr_d, irr_q;

  always_comb begin
    for (int i = 0; i < NUM_LINES; i++) begin
      clr[i]   = ack_i && (ack_id_i == IDW'(i));
      irr_d[i] = lvl_mode_i[i] ? sync_i[i] : (rise_i[i] | (irr_q[i] & ~clr[i]));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irr_q <= '0;
    else     irr_q <= irr_d;
  end

  assign irr_o = irr_q;

  genvar g;
  generate
    for (g = 0; g < NUM_LINES; g++) begin : g_chk
      p_edge_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!lvl_mode_i[g] && irr_q[g] && !clr[g]) |=> irr_q[g]);
      p_edge_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (!lvl_mode_i[g] && !rise_i[g] && !irr_q[g]) |=> !irr_q[g]);
      p_edge_wins_r4: assert property (@(posedge clk) disable iff (rst)
        (!lvl_mode_i[g] && rise_i[g] && clr[g]) |=> irr_q[g]);
      p_level_follow_r5: assert property (@(posedge clk) disable iff (rst)
        lvl_mode_i[g] |=> (irr_q[g] == $past(sync_i[g])));
    end
  endgenerate
endmodule

// File: rtl/irq_cfg_regs.sv
module irq_cfg_regs
  import irq_fe_pkg::*;
#(
  parameter int          NUM_LINES = 16,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] SEL_BASE  = 16'h04D0,
  parameter logic [15:0] CTRL_ADDR = 16'h04D2,
  localparam int NBYTES = NUM_LINES / 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic                 rd_i,
  input  logic [7:0]           wdata_i,
  output logic [7:0]           rdata_o,
  output logic [NUM_LINES-1:0] sel_o,
  output logic                 men_o,
  output logic                 glvl_o,
  output logic                 ovr_o
);
  logic [NUM_LINES-1:0] sel_q;
  logic [CTRL_BITS-1:0] ctrl_q;
  logic [7:0]           rmux, rdata_q;

  always_comb begin
    rmux = '0;
    for (int k = 0; k < NBYTES; k++)
      if (addr_i == ADDR_W'(SEL_BASE + 16'(k))) rmux = sel_q[k*8 +: 8];
    if (addr_i == ADDR_W'(CTRL_ADDR)) rmux = {{(8-CTRL_BITS){1'b0}}, ctrl_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q   <= '0;
      ctrl_q  <= '0;
      rdata_q <= '0;
    end else begin
      if (wr_i) begin
        for (int k = 0; k < NBYTES; k++)
          if (addr_i == ADDR_W'(SEL_BASE + 16'(k))) sel_q[k*8 +: 8] <= wdata_i;
        if (addr_i == ADDR_W'(CTRL_ADDR)) ctrl_q <= wdata_i[CTRL_BITS-1:0];
      end
      if (rd_i) rdata_q <= rmux;
    end
  end

  assign rdata_o = rdata_q;
  assign sel_o   = sel_q;
  assign men_o   = ctrl_q[CTRL_MEN];
  assign glvl_o  = ctrl_q[CTRL_GLVL];
  assign ovr_o   = ctrl_q[CTRL_OVR];

  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (sel_q == '0 && ctrl_q == '0 && rdata_q == '0));
endmodule

// File: rtl/irq_edge_level_fe.sv
module irq_edge_level_fe #(
  parameter int          NUM_LINES = 16,
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] SEL_BASE  = 16'h04D0,
  parameter logic [15:0] CTRL_ADDR = 16'h04D2,
  localparam int NBYTES = NUM_LINES / 8,
  localparam int IDW    = $clog2(NUM_LINES),
  localparam int BSW    = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_LINES-1:0] irq_line_i,
  input  logic [ADDR_W-1:0]    io_addr_i,
  input  logic                 io_wr_i,
  input  logic                 io_rd_i,
  input  logic [7:0]           io_wdata_i,
  output logic [7:0]           io_rdata_o,
  input  logic [BSW-1:0]       irr_sel_i,
  output logic [7:0]           irr_byte_o,
  input  logic                 ack_i,
  input  logic [IDW-1:0]       ack_irq_i,
  output logic                 int_o
);
  logic [NUM_LINES-1:0] sync, rise, sel_bits, lvl_mode, irr;
  logic                 men, glvl, ovr;
  logic [7:0]           byte_mux, irr_byte_q;
  logic                 int_q;

  irq_sync_edge #(.NUM_LINES(NUM_LINES)) u_sync (
    .clk(clk), .rst(rst), .line_i(irq_line_i), .sync_o(sync), .rise_o(rise));

  irq_cfg_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .SEL_BASE(SEL_BASE),
                 .CTRL_ADDR(CTRL_ADDR)) u_cfg (
    .clk(clk), .rst(rst), .addr_i(io_addr_i), .wr_i(io_wr_i), .rd_i(io_rd_i),
    .wdata_i(io_wdata_i), .rdata_o(io_rdata_o), .sel_o(sel_bits),
    .men_o(men), .glvl_o(glvl), .ovr_o(ovr));

  assign lvl_mode = ovr ? sel_bits : {NUM_LINES{glvl}};

  irq_pend_reg #(.NUM_LINES(NUM_LINES)) u_pend (
    .clk(clk), .rst(rst), .sync_i(sync), .rise_i(rise), .lvl_mode_i(lvl_mode),
    .ack_i(ack_i), .ack_id_i(ack_irq_i), .irr_o(irr));

  always_comb begin
    byte_mux = '0;
    for (int k = 0; k < NBYTES; k++)
      if (irr_sel_i == BSW'(k)) byte_mux = irr[k*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr_byte_q <= '0;
      int_q      <= 1'b0;
    end else begin
      irr_byte_q <= byte_mux;
      int_q      <= men & (|irr);
    end
  end

  assign irr_byte_o = irr_byte_q;
  assign int_o      = int_q;

  p_int_gated_r8: assert property (@(posedge clk) disable iff (rst)
    !men |=> !int_o);
  p_int_idle_r8: assert property (@(posedge clk) disable iff (rst)
    (irr == '0) |=> !int_o);
endmodule

// File: tb/test_irq_edge_level_fe.sv
`timescale 1ns/1ps
module test_irq_edge_level_fe;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_line = '0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        irr_sel = 1'b0;
  logic [7:0]  irr_byte;
  logic        ack = 1'b0;
  logic [3:0]  ack_id = '0;
  logic        int_w;
  logic        irr_rd = 1'b0;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int exp; bit from_irr; string tag; } item_t;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  irq_edge_level_fe i_irq_edge_level_fe (
    .clk(clk), .rst(rst), .irq_line_i(irq_line), .io_addr_i(io_addr),
    .io_wr_i(io_wr), .io_rd_i(io_rd), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata),
    .irr_sel_i(irr_sel), .irr_byte_o(irr_byte), .ack_i(ack), .ack_irq_i(ack_id),
    .int_o(int_w));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read results and compares with the registered outputs
  initial begin
    forever begin
      @(posedge clk);
      if (io_rd || irr_rd) begin
        item_t it;
        it = sb_q.pop_front();
        @(negedge clk);
        check(it.tag, it.from_irr ? int'(irr_byte) : int'(io_rdata), it.exp);
      end
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic io_read(input logic [15:0] a, input int exp, input string tag);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    sb_q.push_back('{exp, 1'b0, tag});
    @(negedge clk); io_rd = 1'b0;
  endtask

  task automatic irr_read(input logic s, input int exp, input string tag);
    @(negedge clk); irr_sel = s; irr_rd = 1'b1;
    sb_q.push_back('{exp, 1'b1, tag});
    @(negedge clk); irr_rd = 1'b0;
  endtask

  task automatic do_ack(input int n);
    @(negedge clk); ack = 1'b1; ack_id = 4'(n);
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    wait_clk(4);
    @(negedge clk); rst = 1'b0;
    // R1 reset state
    check("R1 int_o after reset", int'(int_w), 0);
    io_read(16'h04D0, 8'h00, "R1 select lo reset");
    io_read(16'h04D1, 8'h00, "R1 select hi reset");
    io_read(16'h04D2, 8'h00, "R1 control reset");
    irr_read(1'b0, 8'h00, "R1 pending lo reset");
    irr_read(1'b1, 8'h00, "R1 pending hi reset");

    // R6 select register write/readback, every bit
    io_write(16'h04D0, 8'hA5); io_write(16'h04D1, 8'h5A);
    io_read(16'h04D0, 8'hA5, "R6 select lo A5");
    io_read(16'h04D1, 8'h5A, "R6 select hi 5A");
    io_write(16'h04D0, 8'hFF); io_write(16'h04D1, 8'hFF);
    io_read(16'h04D0, 8'hFF, "R6 select lo all bits");
    io_read(16'h04D1, 8'hFF, "R6 select hi all bits");
    io_write(16'h04D0, 8'h00); io_write(16'h04D1, 8'h00);

    // R10 unmapped address
    io_write(16'h04D3, 8'hFF);
    io_write(16'h00D0, 8'hFF);
    io_read(16'h04D3, 8'h00, "R10 unmapped read");
    io_read(16'h04D2, 8'h00, "R10 control untouched");
    io_read(16'h04D0, 8'h00, "R10 select untouched");

    // R2 edge capture, R8 gating by master enable
    @(negedge clk); irq_line[3] = 1'b1;
    wait_clk(5);
    irr_read(1'b0, 8'h08, "R2 rising edge latched");
    check("R8 int_o low while disabled", int'(int_w), 0);
    io_write(16'h04D2, 8'h01);
    wait_clk(2);
    check("R8 int_o high when enabled", int'(int_w), 1);

    // R3 ack for another line leaves bit, own ack clears
    do_ack(4); wait_clk(2);
    irr_read(1'b0, 8'h08, "R3 other ack no effect");
    do_ack(3); wait_clk(4);
    irr_read(1'b0, 8'h00, "R2 held-high line no new request");
    check("R8 int_o low when nothing pending", int'(int_w), 0);

    // R9 high byte
    @(negedge clk); irq_line[3] = 1'b0; irq_line[10] = 1'b1;
    wait_clk(5);
    irr_read(1'b1, 8'h04, "R9 pending hi byte line 10");
    irr_read(1'b0, 8'h00, "R9 pending lo byte");
    do_ack(10); wait_clk(3);
    irr_read(1'b1, 8'h00, "R3 ack clears line 10");
    @(negedge clk); irq_line[10] = 1'b0;

    // R4 rising edge beats simultaneous ack
    @(negedge clk); irq_line[5] = 1'b1;
    wait_clk(4);
    @(negedge clk); irq_line[5] = 1'b0;
    wait_clk(5);
    irr_read(1'b0, 8'h20, "R2 line 5 latched");
    @(negedge clk); irq_line[5] = 1'b1;
    @(negedge clk);
    @(negedge clk); ack = 1'b1; ack_id = 4'd5;
    @(negedge clk); ack = 1'b0;
    wait_clk(3);
    irr_read(1'b0, 8'h20, "R4 edge wins over ack");
    @(negedge clk); irq_line[5] = 1'b0;
    wait_clk(4);
    do_ack(5); wait_clk(3);
    irr_read(1'b0, 8'h00, "R3 ack clears line 5");

    // R5 per-line level mode via override
    io_write(16'h04D0, 8'h40);
    io_write(16'h04D2, 8'h05);
    @(negedge clk); irq_line[6] = 1'b1;
    wait_clk(5);
    irr_read(1'b0, 8'h40, "R5 level line pending");
    do_ack(6); wait_clk(3);
    irr_read(1'b0, 8'h40, "R5 ack no lasting effect");
    check("R5 int_o stays high", int'(int_w), 1);
    @(negedge clk); irq_line[6] = 1'b0;
    wait_clk(5);
    irr_read(1'b0, 8'h00, "R5 level bit follows low line");

    // R7 global mode with override off
    io_write(16'h04D2, 8'h03);
    @(negedge clk); irq_line[12] = 1'b1;
    wait_clk(5);
    irr_read(1'b1, 8'h10, "R7 global level pending");
    @(negedge clk); irq_line[12] = 1'b0;
    wait_clk(5);
    irr_read(1'b1, 8'h00, "R7 global level follows line");
    // override on: line 12 select bit is 0 -> edge
    io_write(16'h04D2, 8'h05);
    @(negedge clk); irq_line[12] = 1'b1;
    wait_clk(4);
    @(negedge clk); irq_line[12] = 1'b0;
    wait_clk(5);
    irr_read(1'b1, 8'h10, "R7 per-line edge keeps pending");

    // R8 master disable with pending
    io_write(16'h04D2, 8'h04);
    wait_clk(2);
    check("R8 int_o low after disable", int'(int_w), 0);
    do_ack(12); wait_clk(3);
    irr_read(1'b1, 8'h00, "R3 ack clears line 12");
    io_read(16'h04D2, 8'h04, "R7 control readback");

    wait_clk(3);
    finish_run();
  end
endmodule